// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit with Result Pair

This block is an iterative 32-bit integer arithmetic engine for multiplication and division. It has a private pair of result registers, HI and LO. A caller pulses a start request with an operation code and two operands. The unit captures both operands, raises busy while it works, and spends one iteration per operand bit. Multiplication uses a shift-and-add loop and division uses a restoring loop. When the result is committed, the unit raises done for one cycle. The contents of HI and LO depend on the last operation:

- After a multiply, HI holds the upper half of the 64-bit product and LO holds the lower half.
- After a divide, HI holds the remainder and LO holds the quotient.

Both registers can be read at any time through their own output ports. The surrounding pipeline copies them into general registers from there.

Each operation can treat its operands as unsigned or as two's complement. Signed results come from a magnitude computation followed by a sign fix-up. No arithmetic exception is ever produced. Division by zero and the signed minimum divided by minus one both complete with fixed, documented values.

A separate three-operand multiply form returns the low 32 product bits on its own output and leaves HI and LO untouched.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, busy and done are low and the HI, LO and three-operand result outputs are all zero.
- R2: Operation code 3'b001 (unsigned multiply) treats both operands as unsigned. HI receives product bits 63:32 and LO receives product bits 31:0.
- R3: Operation code 3'b000 (signed multiply) treats both operands as two's complement and stores the 64-bit signed product as HI (bits 63:32) and LO (bits 31:0).
- R4: Operation code 3'b011 (unsigned divide) puts the unsigned quotient in LO and the remainder in HI.
- R5: Operation code 3'b010 (signed divide) truncates the quotient toward zero, and the remainder carries the sign of the dividend. The signed minimum divided by minus one yields LO = 32'h80000000 and HI = 0, with no exception.
- R6: A divide with a zero divisor, signed or unsigned, completes normally with LO = 32'hFFFFFFFF and HI equal to the dividend.
- R7: A start is accepted on a clock edge where busy is low. Busy is high from that edge for 33 cycles. Done is high for exactly one cycle, beginning 33 edges after the accepting edge, and busy falls on that same edge.
- R8: A start request while busy is high is ignored. The running operation's result and latency are unaffected, and no further operation follows it.
- R9: Operation code 3'b100 (three-operand multiply) drives the low 32 bits of the signed product on the three-operand result output at done and leaves HI and LO unchanged.
- R10: Operation codes 3'b101 to 3'b111 are reserved. A start carrying one of them never raises busy or done and changes no output.
- R11: HI and LO change only on the edge where done rises, never at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin an operation |
| op_i | input | 3 | Operation code (see R2 to R10) |
| src_a_i | input | 32 | First operand: multiplicand or dividend |
| src_b_i | input | 32 | Second operand: multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | HI register: product upper half or remainder |
| lo_o | output | 32 | LO register: product lower half or quotient |
| mul_lo_o | output | 32 | Result of the three-operand multiply |

## Verification
The assertions check the following on every cycle:

- Done is a single-cycle pulse that closes a busy window of exactly 33 cycles.
- HI and LO only move on a done edge, and stay frozen on a three-operand multiply completion.
- The captured operands cannot move while busy.
- Reserved codes never raise busy.
- A zero divisor always commits all-ones and the dividend.
- Each restoring step keeps the partial remainder below a nonzero divisor.

Only the bench's scenarios can show that the numeric results are correct. That covers sign fix-ups for all four sign combinations, the unsigned extremes, and the signed minimum divided by minus one. The scenarios also show that a start arriving mid-operation neither alters the result nor launches a second run.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;

  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    MD_MUL_S  = 3'd0,
    MD_MUL_U  = 3'd1,
    MD_DIV_S  = 3'd2,
    MD_DIV_U  = 3'd3,
    MD_MUL_LO = 3'd4
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_e;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_is_div(input md_op_e op);
    return (op == MD_DIV_S) || (op == MD_DIV_U);
  endfunction

  function automatic logic op_is_signed(input md_op_e op);
    return (op == MD_MUL_S) || (op == MD_DIV_S) || (op == MD_MUL_LO);
  endfunction

endpackage

// File: rtl/md_seq.sv
`timescale 1ns/1ps
module md_seq
  import muldiv_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  output logic busy_o,
  output logic step_o,
  output logic fin_o,
  output logic done_o
);

  localparam int CW = $clog2(W);
  localparam int LW = CW + 2;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  md_state_e     state_q;
  logic [CW-1:0] iter_q;
  logic          done_q;

  assign busy_o = (state_q != ST_IDLE);
  assign step_o = (state_q == ST_RUN);
  assign fin_o  = (state_q == ST_FIN);
  assign done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_FIN);
      unique case (state_q)
        ST_IDLE: begin
          if (accept_i) begin
            state_q <= ST_RUN;
            iter_q  <= '0;
          end
        end
        ST_RUN: begin
          if (iter_q == LAST) state_q <= ST_FIN;
          else                iter_q  <= iter_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Checker-side span counter for the busy window
  logic [LW-1:0] span_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      span_q <= '0;
    else if (busy_o) span_q <= span_q + 1'b1;
    else             span_q <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (span_q == LW'(W + 1))); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o); // R7

endmodule

// File: rtl/md_mul_core.sv
`timescale 1ns/1ps
module md_mul_core
  import muldiv_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);

  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [W:0]     upper_sum;

  // Add the multiplicand into the upper half when the current multiplier bit is set
  always_comb begin
    upper_sum = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q  <= {upper_sum, prod_q[W-1:1]};
    end
  end

  assign prod_o = prod_q;

  AST_MCAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> $stable(mcand_q)); // R2

endmodule

// File: rtl/md_div_core.sv
`timescale 1ns/1ps
module md_div_core
  import muldiv_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] dvs_q;
  logic [W:0]   shifted;
  logic [W:0]   trial;
  logic         fits;

  // One restoring step: bring in the next dividend bit, subtract if it fits
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    fits    = (shifted >= {1'b0, dvs_q});
    trial   = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dividend_i;
      dvs_q <= divisor_i;
    end else if (step_i) begin
      rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (dvs_q != '0)) |=> (rem_q < dvs_q)); // R4

endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] src_a_i,
  input  logic [W-1:0] src_b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] mul_lo_o
);

  // Arithmetic helpers for the sign handling around the magnitude cores
  function automatic logic [W-1:0] to_mag(input logic [W-1:0] v, input logic sgn);
    return (sgn && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [W-1:0] neg_if(input logic [W-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [2*W-1:0] neg_if2(input logic [2*W-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  md_op_e       op_in;
  logic         accept;
  logic         busy;
  logic         step;
  logic         fin;
  logic         in_signed;

  md_op_e       op_q;
  logic [W-1:0] a_q;
  logic         a_neg_q;
  logic         b_neg_q;
  logic         b_zero_q;

  logic [W-1:0]   hi_q;
  logic [W-1:0]   lo_q;
  logic [W-1:0]   ml_q;
  logic [W-1:0]   mag_a;
  logic [W-1:0]   mag_b;
  logic [2*W-1:0] prod_raw;
  logic [2*W-1:0] prod_fix;
  logic [W-1:0]   quo_raw;
  logic [W-1:0]   rem_raw;
  logic [W-1:0]   quo_fix;
  logic [W-1:0]   rem_fix;
  logic           load_mul;
  logic           load_div;

  assign op_in     = md_op_e'(op_i);
  assign accept    = start_i && !busy && op_known(op_i);
  assign in_signed = op_is_signed(op_in);
  assign mag_a     = to_mag(src_a_i, in_signed);
  assign mag_b     = to_mag(src_b_i, in_signed);
  assign load_mul  = accept && !op_is_div(op_in);
  assign load_div  = accept &&  op_is_div(op_in);

  md_seq #(.W(W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .busy_o   (busy),
    .step_o   (step),
    .fin_o    (fin),
    .done_o   (done_o)
  );

  md_mul_core #(.W(W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_mul),
    .step_i   (step && !op_is_div(op_q)),
    .mcand_i  (mag_a),
    .mplier_i (mag_b),
    .prod_o   (prod_raw)
  );

  md_div_core #(.W(W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_div),
    .step_i     (step && op_is_div(op_q)),
    .dividend_i (mag_a),
    .divisor_i  (mag_b),
    .quo_o      (quo_raw),
    .rem_o      (rem_raw)
  );

  // Operand side information captured at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= MD_MUL_S;
      a_q      <= '0;
      a_neg_q  <= 1'b0;
      b_neg_q  <= 1'b0;
      b_zero_q <= 1'b0;
    end else if (accept) begin
      op_q     <= op_in;
      a_q      <= src_a_i;
      a_neg_q  <= in_signed && src_a_i[W-1];
      b_neg_q  <= in_signed && src_b_i[W-1];
      b_zero_q <= (src_b_i == '0);
    end
  end

  assign prod_fix = neg_if2(prod_raw, a_neg_q ^ b_neg_q);
  assign quo_fix  = neg_if(quo_raw, a_neg_q ^ b_neg_q);
  assign rem_fix  = neg_if(rem_raw, a_neg_q);

  // Commit results on the final state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      ml_q <= '0;
    end else if (fin) begin
      unique case (op_q)
        MD_MUL_S, MD_MUL_U: begin
          hi_q <= prod_fix[2*W-1:W];
          lo_q <= prod_fix[W-1:0];
        end
        MD_MUL_LO: ml_q <= prod_fix[W-1:0];
        MD_DIV_S, MD_DIV_U: begin
          if (b_zero_q) begin
            lo_q <= '1;
            hi_q <= a_q;
          end else begin
            lo_q <= quo_fix;
            hi_q <= rem_fix;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy_o   = busy;
  assign hi_o     = hi_q;
  assign lo_o     = lo_q;
  assign mul_lo_o = ml_q;

  AST_HILO_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(hi_o) && $stable(lo_o)) |-> done_o); // R11
  AST_MUL_LO_KEEPS_HILO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (op_q == MD_MUL_LO)) |-> ($stable(hi_o) && $stable(lo_o))); // R9
  AST_BUSY_LOCKS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(op_q) && $stable(a_q) && $stable(b_zero_q))); // R8
  AST_DIV0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_is_div(op_q) && b_zero_q) |-> ((lo_o == '1) && (hi_o == a_q))); // R6
  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (op_i > 3'd4)) |=> !busy_o); // R10

endmodule

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic        busy_o;
  logic        done_o;
  logic [31:0] hi_o;
  logic [31:0] lo_o;
  logic [31:0] mul_lo_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    logic [31:0] ml;
  } exp_t;

  exp_t  sb_q[$];
  string req_q[$];

  logic [31:0] m_hi = '0;
  logic [31:0] m_lo = '0;
  logic [31:0] m_ml = '0;

  always #10 clk = ~clk;

  muldiv_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .hi_o     (hi_o),
    .lo_o     (lo_o),
    .mul_lo_o (mul_lo_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  // Monitor: pop an expected item on every completion
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) begin
        chk("R8", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t  e;
        string r;
        e = sb_q.pop_front();
        r = req_q.pop_front();
        chk(r, "hi", hi_o, e.hi);
        chk(r, "lo", lo_o, e.lo);
        chk(r, "mul_lo", mul_lo_o, e.ml);
      end
    end
  end

  // Reference model built from the requirement text
  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa;
    logic signed [63:0] sb;
    logic signed [63:0] sp;
    logic [63:0]        up;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    case (op)
      3'd0: begin sp = sa * sb; m_hi = sp[63:32]; m_lo = sp[31:0]; end
      3'd1: begin up = {32'b0, a} * {32'b0, b}; m_hi = up[63:32]; m_lo = up[31:0]; end
      3'd2: begin
        if (b == 0) begin m_lo = '1; m_hi = a; end
        else begin sp = sa / sb; m_lo = sp[31:0]; sp = sa % sb; m_hi = sp[31:0]; end
      end
      3'd3: begin
        if (b == 0) begin m_lo = '1; m_hi = a; end
        else begin m_lo = a / b; m_hi = a % b; end
      end
      3'd4: begin sp = sa * sb; m_ml = sp[31:0]; end
      default: ;
    endcase
  endtask

  // Driver: push expectation, issue the request, time the completion
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input string req, input bit poke);
    exp_t e;
    int   n;
    model(op, a, b);
    e.hi = m_hi; e.lo = m_lo; e.ml = m_ml;
    sb_q.push_back(e);
    req_q.push_back(req);
    start_i = 1'b1; op_i = op; src_a_i = a; src_b_i = b;
    @(negedge clk);
    start_i = 1'b0; src_a_i = ~a; src_b_i = 32'h5A5A_0F0F;
    chk("R7", "busy after accept", {31'b0, busy_o}, 32'd1);
    n = 1;
    while (!done_o && n < 100) begin
      @(negedge clk);
      n++;
      if (poke && n == 5) begin
        start_i = 1'b1; op_i = 3'd1; src_a_i = 32'd3; src_b_i = 32'd5;
      end
      if (poke && n == 6) start_i = 1'b0;
    end
    chk("R7", "done latency", n, 32'd34);
    chk("R7", "busy low at done", {31'b0, busy_o}, 32'd0);
    @(negedge clk);
    chk(poke ? "R8" : "R7", "done one cycle / idle after", {30'b0, busy_o, done_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'b0, busy_o}, 32'd0);
    chk("R1", "done", {31'b0, done_o}, 32'd0);
    chk("R1", "hi", hi_o, 32'd0);
    chk("R1", "lo", lo_o, 32'd0);
    chk("R1", "mul_lo", mul_lo_o, 32'd0);

    // R2 unsigned multiply
    run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2", 1'b0);
    chk("R2", "max*max hi literal", hi_o, 32'hFFFF_FFFE);
    run_op(3'd1, 32'h1234_5678, 32'h9ABC_DEF0, "R2", 1'b0);
    run_op(3'd1, 32'd0, 32'hDEAD_BEEF, "R2", 1'b0);

    // R3 signed multiply
    run_op(3'd0, 32'hFFFF_FFFD, 32'd7, "R3", 1'b0);
    chk("R3", "-3*7 lo literal", lo_o, 32'hFFFF_FFEB);
    run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3", 1'b0);
    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, "R3", 1'b0);
    run_op(3'd0, 32'h7FFF_FFFF, 32'h8000_0000, "R3", 1'b0);

    // R4 unsigned divide
    run_op(3'd3, 32'd100, 32'd7, "R4", 1'b0);
    chk("R4", "100/7 rem literal", hi_o, 32'd2);
    run_op(3'd3, 32'hFFFF_FFFF, 32'h0000_0010, "R4", 1'b0);
    run_op(3'd3, 32'h8000_0000, 32'hFFFF_FFFF, "R4", 1'b0);

    // R5 signed divide
    run_op(3'd2, 32'hFFFF_FFF9, 32'd2, "R5", 1'b0);
    chk("R5", "-7/2 quotient literal", lo_o, 32'hFFFF_FFFD);
    chk("R5", "-7/2 remainder literal", hi_o, 32'hFFFF_FFFF);
    run_op(3'd2, 32'd7, 32'hFFFF_FFFE, "R5", 1'b0);
    run_op(3'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5", 1'b0);
    run_op(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R5", 1'b0);
    chk("R5", "min/-1 quotient literal", lo_o, 32'h8000_0000);

    // R6 divide by zero
    run_op(3'd3, 32'hCAFE_0001, 32'd0, "R6", 1'b0);
    run_op(3'd2, 32'h8765_4321, 32'd0, "R6", 1'b0);
    chk("R6", "signed div0 hi literal", hi_o, 32'h8765_4321);

    // R9 three-operand multiply keeps HI/LO
    run_op(3'd4, 32'hFFFF_FFFB, 32'd6, "R9", 1'b0);
    chk("R9", "mul_lo literal", mul_lo_o, 32'hFFFF_FFE2);
    chk("R9", "hi kept", hi_o, 32'h8765_4321);

    // R8 start while busy is ignored
    run_op(3'd1, 32'd1000, 32'd1000, "R8", 1'b1);
    repeat (40) @(negedge clk);
    chk("R8", "no second run lo", lo_o, 32'd1000000);

    // R10 reserved codes
    for (int c = 5; c < 8; c++) begin
      int seen;
      seen = 0;
      start_i = 1'b1; op_i = c[2:0]; src_a_i = 32'd9; src_b_i = 32'd9;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < 40; k++) begin
        if (busy_o || done_o) seen++;
        @(negedge clk);
      end
      chk("R10", "busy/done seen", seen, 32'd0);
      chk("R10", "lo unchanged", lo_o, m_lo);
    end

    // R11 all expectations consumed, nothing extra committed
    chk("R11", "pending expectations", sb_q.size(), 32'd0);
    chk("R11", "hi final", hi_o, m_hi);
    finish_run();
  end

endmodule